// File: doc/BRIEF.md
# Multi-Convention Float-to-Integer Converter

This block turns one IEEE binary64 operand into a 32-bit or 64-bit integer, signed or unsigned, and delivers it in a 64-bit general-register result. It can also take an IEEE binary32 operand from the low half of the input word. A three-bit convention code selects how NaN and out-of-range values are handled. Two conventions saturate to the type limits and differ only in where NaN lands. The third reduces the rounded value modulo 2^N and turns NaN and infinity into zero. The low bit of the code forces truncation. When that bit is clear, the rounding comes from a two-bit rounding input.

One request enters per cycle on a valid strobe, and the full outcome comes back one cycle later. That outcome is the integer, a destination write enable, the invalid-conversion and signalling-NaN flags, the inexact and rounded-up flags, an integer-overflow indication and an illegal-code indication. When invalid exceptions are enabled and the conversion is invalid, the write enable is dropped and the inexact and rounded-up flags read zero. Trap delivery is left to the surrounding pipeline.

Top module: `fti_conv`

## Requirements
- R1: Convention code values 0 and 1 select saturation with NaN to the type minimum. Values 2 and 3 select saturation with NaN to zero. Values 4 and 5 select modulo wrapping. Values 6 and 7 raise `out_bad_mode` and clear the write enable, the result and every other flag.
- R2: When bit 0 of the convention code is 1, rounding is truncation. When it is 0, `in_rnd` selects the rounding: 2'b00 nearest-even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity.
- R3: Type code 0 is signed 32, 1 is unsigned 32, 2 is signed 64 and 3 is unsigned 64. A 32-bit signed result is sign-extended to 64 bits, and a 32-bit unsigned result is zero-extended.
- R4: In the saturating conventions, a rounded value above the type maximum gives the maximum and a value below the type minimum gives the minimum, where the unsigned minimum is 0. An in-range value gives the rounded integer itself.
- R5: In the saturating conventions, NaN gives the type minimum for codes 0 and 1, and zero for codes 2 and 3.
- R6: In the wrap convention, the rounded value is reduced modulo 2^32 or 2^64 and the bits are reinterpreted in the target type. NaN and infinity give 0, and a magnitude of at least 2^117 gives 0.
- R7: `out_overflow` is 1 when the source is NaN or infinite, or when the integer result does not equal the source value exactly.
- R8: `out_inv_cvt` is 1 for NaN inputs, for saturated out-of-range inputs, and for infinity in the wrap convention. `out_inv_snan` is 1 only for a NaN whose top fraction bit is 0.
- R9: `out_inexact` is 1 when rounding discarded a nonzero fraction. `out_rounded_up` is 1 when rounding increased the magnitude. Both are 0 on an invalid conversion.
- R10: With `in_inv_en` at 1 and an invalid condition, `out_wr_en` is 0, the result reads 0, and the inexact and rounded-up flags are 0. Otherwise a legal request writes.
- R11: With `in_single` at 1, bits 31:0 of `in_bits` are converted as an IEEE binary32 value and bits 63:32 are ignored.
- R12: All outputs belong to the request accepted at the previous rising edge. `out_valid` is 1 exactly one cycle after `in_valid`, and the outputs reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_bits | input | 64 | Floating-point operand bits |
| in_single | input | 1 | Take bits 31:0 as binary32 |
| in_mode | input | 3 | Convention and truncate-force code |
| in_rnd | input | 2 | Rounding selection |
| in_type | input | 2 | Integer target type |
| in_inv_en | input | 1 | Invalid exception enable |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Integer result |
| out_wr_en | output | 1 | Destination write enable |
| out_inv_cvt | output | 1 | Invalid conversion flag |
| out_inv_snan | output | 1 | Signalling NaN flag |
| out_inexact | output | 1 | Inexact flag |
| out_rounded_up | output | 1 | Magnitude increased by rounding |
| out_overflow | output | 1 | Integer overflow indication |
| out_bad_mode | output | 1 | Illegal convention code |

## Verification
Every result and flag of a request is due exactly one cycle after the request: the datapath is combinational up to a single output register stage. Each scenario drives its inputs at a falling edge and holds them across one rising edge. It then drops the strobe and reads every output at the next falling edge, after the register has loaded and before the next request can change it. The latency check samples `out_valid` on that edge and again one idle cycle later, to show that the strobe lasts one cycle.

// File: rtl/fti_pkg.sv
`timescale 1ns/1ps
package fti_pkg;
   localparam int DBL_EXP_W  = 11;
   localparam int DBL_FRAC_W = 52;
   localparam int SGL_EXP_W  = 8;
   localparam int SGL_FRAC_W = 23;
   localparam int SIG_W      = DBL_FRAC_W + 1;
   localparam int EXPI_W     = DBL_EXP_W + 2;
   localparam int INT_W      = 64;
   localparam int FX_W       = 2 * INT_W;

   typedef enum logic [1:0] {
      IT_S32 = 2'd0, IT_U32 = 2'd1, IT_S64 = 2'd2, IT_U64 = 2'd3
   } itype_e;

   typedef enum logic [1:0] {
      SEM_SAT_MIN = 2'd0, SEM_SAT_ZERO = 2'd1, SEM_WRAP = 2'd2, SEM_BAD = 2'd3
   } sem_e;

   typedef enum logic [1:0] {
      RM_NEAR = 2'd0, RM_TRUNC = 2'd1, RM_CEIL = 2'd2, RM_FLOOR = 2'd3
   } rmode_e;

   typedef struct packed {
      logic              sign;
      logic              is_nan;
      logic              is_snan;
      logic              is_inf;
      logic [EXPI_W-1:0] exp;
      logic [SIG_W-1:0]  sig;
   } opnd_t;

   typedef struct packed {
      logic             valid;
      logic             wr;
      logic [INT_W-1:0] result;
      logic             cvi;
      logic             snan;
      logic             xx;
      logic             fr;
      logic             ovf;
      logic             bad;
   } resp_t;
endpackage

// File: rtl/fti_unpack.sv
`timescale 1ns/1ps
module fti_unpack
   import fti_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52
) (
   input  logic [EXP_W+FRAC_W:0] bits,
   output opnd_t                 op
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int PAD  = SIG_W - 1 - FRAC_W;

   if (FRAC_W > SIG_W - 1 || EXP_W > EXPI_W - 2) begin : g_bad_fmt
      $error("fti_unpack: format does not fit the internal operand");
   end

   logic [EXP_W-1:0]  ef;
   logic [FRAC_W-1:0] ff;
   logic              emax, ez;

   always_comb begin
      ef   = bits[EXP_W+FRAC_W-1 -: EXP_W];
      ff   = bits[FRAC_W-1:0];
      emax = &ef;
      ez   = ~|ef;
      op.sign    = bits[EXP_W+FRAC_W];
      op.is_nan  = emax & (|ff);
      op.is_snan = emax & (|ff) & ~ff[FRAC_W-1];
      op.is_inf  = emax & ~(|ff);
      op.sig     = SIG_W'({~ez, ff}) << PAD;
      op.exp     = ez ? EXPI_W'(1 - BIAS) : (EXPI_W'(ef) - EXPI_W'(BIAS));
   end
endmodule

// File: rtl/fti_round.sv
`timescale 1ns/1ps
module fti_round
   import fti_pkg::*;
(
   input  opnd_t            op,
   input  rmode_e           rmode,
   output logic [INT_W:0]   mag,
   output logic             big,
   output logic             rbit,
   output logic             sbit,
   output logic             inc
);
   localparam int HALF    = FX_W / 2;
   localparam int LSB_OFS = HALF - (SIG_W - 1);
   localparam int AMT_W   = $clog2(FX_W);
   localparam int SH_W    = $clog2(INT_W);

   logic signed [EXPI_W-1:0] e, sh;
   logic [FX_W-1:0]          fx;
   logic [INT_W-1:0]         ipart;

   always_comb begin
      e     = $signed(op.exp);
      sh    = '0;
      fx    = '0;
      ipart = '0;
      rbit  = 1'b0;
      sbit  = 1'b0;
      big   = 1'b0;
      if (op.is_inf || op.is_nan) begin
         big = op.is_inf;
      end else if (e >= EXPI_W'(INT_W)) begin
         big = 1'b1;
         sh  = e - EXPI_W'(SIG_W - 1);
         if (sh < EXPI_W'(INT_W)) ipart = INT_W'(op.sig) << sh[SH_W-1:0];
      end else if (e >= -EXPI_W'(2)) begin
         fx    = FX_W'(op.sig) << AMT_W'(e + EXPI_W'(LSB_OFS));
         ipart = fx[FX_W-1:HALF];
         rbit  = fx[HALF-1];
         sbit  = |fx[HALF-2:0];
      end else begin
         sbit = |op.sig;
      end

      unique case (rmode)
         RM_NEAR:  inc = rbit & (sbit | ipart[0]);
         RM_TRUNC: inc = 1'b0;
         RM_CEIL:  inc = ~op.sign & (rbit | sbit);
         default:  inc = op.sign & (rbit | sbit);
      endcase
      mag = {1'b0, ipart} + (INT_W+1)'(inc);
   end
endmodule

// File: rtl/fti_select.sv
`timescale 1ns/1ps
module fti_select
   import fti_pkg::*;
(
   input  opnd_t            op,
   input  logic [INT_W:0]   mag,
   input  logic             big,
   input  logic             rbit,
   input  logic             sbit,
   input  logic             inc,
   input  sem_e             sem,
   input  itype_e           ityp,
   output logic [INT_W-1:0] result,
   output logic             cvi,
   output logic             snan,
   output logic             xx,
   output logic             fr,
   output logic             ovf
);
   localparam int NW = INT_W / 2;

   logic             is32, uns, legal, above, below, oor;
   logic [INT_W:0]   pos_lim, neg_lim;
   logic [INT_W-1:0] maxv, minv, raw, fitted;

   always_comb begin
      is32  = ~ityp[1];
      uns   = ityp[0];
      legal = (sem != SEM_BAD);

      pos_lim = is32 ? (INT_W+1)'({NW{1'b1}} >> ~uns)
                     : (INT_W+1)'({INT_W{1'b1}} >> ~uns);
      neg_lim = uns ? '0 : ((INT_W+1)'(1) << (is32 ? NW - 1 : INT_W - 1));
      maxv    = pos_lim[INT_W-1:0];
      minv    = uns ? '0 : (is32 ? {{(INT_W-NW+1){1'b1}}, {(NW-1){1'b0}}}
                                 : {1'b1, {(INT_W-1){1'b0}}});

      above = ~op.sign & (big | (mag > pos_lim));
      below =  op.sign & (big | (mag > neg_lim));
      oor   = above | below;

      raw    = op.sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
      fitted = !is32 ? raw
             : (uns ? {{(INT_W-NW){1'b0}}, raw[NW-1:0]}
                    : {{(INT_W-NW){raw[NW-1]}}, raw[NW-1:0]});

      result = '0;
      cvi    = 1'b0;
      unique case (sem)
         SEM_SAT_MIN, SEM_SAT_ZERO: begin
            if (op.is_nan) begin
               result = (sem == SEM_SAT_MIN) ? minv : '0;
               cvi    = 1'b1;
            end else if (above) begin
               result = maxv;
               cvi    = 1'b1;
            end else if (below) begin
               result = minv;
               cvi    = 1'b1;
            end else begin
               result = fitted;
            end
         end
         SEM_WRAP: begin
            if (op.is_nan || op.is_inf) cvi = 1'b1;
            else                        result = fitted;
         end
         default: result = '0;
      endcase

      snan = legal & op.is_snan;
      xx   = legal & ~cvi & (rbit | sbit);
      fr   = legal & ~cvi & inc;
      ovf  = legal & (op.is_nan | op.is_inf | rbit | sbit | oor);
   end
endmodule

// File: rtl/fti_conv.sv
`timescale 1ns/1ps
module fti_conv
   import fti_pkg::*;
#(
   parameter int RES_W   = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [63:0]      in_bits,
   input  logic             in_single,
   input  logic [2:0]       in_mode,
   input  logic [1:0]       in_rnd,
   input  logic [1:0]       in_type,
   input  logic             in_inv_en,
   output logic             out_valid,
   output logic [RES_W-1:0] out_result,
   output logic             out_wr_en,
   output logic             out_inv_cvt,
   output logic             out_inv_snan,
   output logic             out_inexact,
   output logic             out_rounded_up,
   output logic             out_overflow,
   output logic             out_bad_mode
);
   localparam int NFMT = 2;

   if (RES_W != INT_W) begin : g_bad_width
      $error("fti_conv: RES_W must match the package integer width");
   end

   opnd_t fmt_op [NFMT];

   for (genvar g = 0; g < NFMT; g++) begin : g_fmt
      localparam int EW = (g == 0) ? DBL_EXP_W  : SGL_EXP_W;
      localparam int FW = (g == 0) ? DBL_FRAC_W : SGL_FRAC_W;
      fti_unpack #(.EXP_W(EW), .FRAC_W(FW)) u_unp (
         .bits (in_bits[EW+FW:0]),
         .op   (fmt_op[g])
      );
   end

   opnd_t            op;
   sem_e             sem;
   rmode_e           rmode;
   logic [INT_W:0]   mag;
   logic             big, rbit, sbit, inc;
   logic [INT_W-1:0] res;
   logic             cvi, snan, xx, fr, ovf, legal, vex;
   resp_t            nxt, q;

   always_comb begin
      op    = in_single ? fmt_op[1] : fmt_op[0];
      sem   = sem_e'(in_mode[2:1]);
      rmode = in_mode[0] ? RM_TRUNC : rmode_e'(in_rnd);
   end

   fti_round u_rnd (
      .op    (op),
      .rmode (rmode),
      .mag   (mag),
      .big   (big),
      .rbit  (rbit),
      .sbit  (sbit),
      .inc   (inc)
   );

   fti_select u_sel (
      .op     (op),
      .mag    (mag),
      .big    (big),
      .rbit   (rbit),
      .sbit   (sbit),
      .inc    (inc),
      .sem    (sem),
      .ityp   (itype_e'(in_type)),
      .result (res),
      .cvi    (cvi),
      .snan   (snan),
      .xx     (xx),
      .fr     (fr),
      .ovf    (ovf)
   );

   always_comb begin
      legal      = (sem != SEM_BAD);
      vex        = in_inv_en & (cvi | snan);
      nxt.valid  = in_valid;
      nxt.wr     = in_valid & legal & ~vex;
      nxt.result = nxt.wr ? res : '0;
      nxt.cvi    = in_valid & cvi;
      nxt.snan   = in_valid & snan;
      nxt.xx     = in_valid & xx & ~vex;
      nxt.fr     = in_valid & fr & ~vex;
      nxt.ovf    = in_valid & ovf;
      nxt.bad    = in_valid & ~legal;
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end

      assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_bad_mode_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
         out_bad_mode |-> (!out_wr_en && !out_inv_cvt && !out_overflow && !out_inexact));
      assert_snan_is_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
         out_inv_snan |-> out_inv_cvt);
      assert_invalid_overflows_R7: assert property (@(posedge clk) disable iff (!rst_n)
         out_inv_cvt |-> out_overflow);
      assert_roundup_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
         out_rounded_up |-> out_inexact);
      assert_nowrite_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_wr_en) |-> (!out_inexact && !out_rounded_up && out_result == '0));
   end else begin : g_comb
      always_comb q = nxt;
   end

   always_comb begin
      out_valid      = q.valid;
      out_result     = q.result;
      out_wr_en      = q.wr;
      out_inv_cvt    = q.cvi;
      out_inv_snan   = q.snan;
      out_inexact    = q.xx;
      out_rounded_up = q.fr;
      out_overflow   = q.ovf;
      out_bad_mode   = q.bad;
   end
endmodule

// File: tb/fti_conv_test.sv
`timescale 1ns/1ps
module fti_conv_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_bits = '0;
   logic        in_single = 1'b0;
   logic [2:0]  in_mode = '0;
   logic [1:0]  in_rnd = '0;
   logic [1:0]  in_type = '0;
   logic        in_inv_en = 1'b0;
   logic        out_valid, out_wr_en, out_inv_cvt, out_inv_snan;
   logic        out_inexact, out_rounded_up, out_overflow, out_bad_mode;
   logic [63:0] out_result;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   fti_conv uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
      .in_single(in_single), .in_mode(in_mode), .in_rnd(in_rnd),
      .in_type(in_type), .in_inv_en(in_inv_en), .out_valid(out_valid),
      .out_result(out_result), .out_wr_en(out_wr_en), .out_inv_cvt(out_inv_cvt),
      .out_inv_snan(out_inv_snan), .out_inexact(out_inexact),
      .out_rounded_up(out_rounded_up), .out_overflow(out_overflow),
      .out_bad_mode(out_bad_mode)
   );

   localparam logic [63:0] D_2P5   = 64'h4004_0000_0000_0000;
   localparam logic [63:0] D_3P5   = 64'h400C_0000_0000_0000;
   localparam logic [63:0] D_N2P5  = 64'hC004_0000_0000_0000;
   localparam logic [63:0] D_NHALF = 64'hBFE0_0000_0000_0000;
   localparam logic [63:0] D_1P5   = 64'h3FF8_0000_0000_0000;
   localparam logic [63:0] D_2     = 64'h4000_0000_0000_0000;
   localparam logic [63:0] D_N1    = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] D_NZERO = 64'h8000_0000_0000_0000;
   localparam logic [63:0] D_P31   = 64'h41E0_0000_0000_0000;
   localparam logic [63:0] D_N31   = 64'hC1E0_0000_0000_0000;
   localparam logic [63:0] D_P63   = 64'h43E0_0000_0000_0000;
   localparam logic [63:0] D_N63   = 64'hC3E0_0000_0000_0000;
   localparam logic [63:0] D_P64   = 64'h43F0_0000_0000_0000;
   localparam logic [63:0] D_P32P5 = 64'h41F0_0000_0050_0000;
   localparam logic [63:0] D_P64P12= 64'h43F0_0000_0000_0001;
   localparam logic [63:0] D_P117  = 64'h4740_0000_0000_0000;
   localparam logic [63:0] D_PINF  = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] D_NINF  = 64'hFFF0_0000_0000_0000;
   localparam logic [63:0] D_QNAN  = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] D_SNAN  = 64'h7FF0_0000_0000_0001;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [63:0] b, input logic sg, input logic [2:0] m,
                        input logic [1:0] r, input logic [1:0] t, input logic ve);
      @(negedge clk);
      in_bits = b; in_single = sg; in_mode = m; in_rnd = r; in_type = t;
      in_inv_en = ve; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic conv(input string req, input logic [63:0] b, input logic sg,
                       input logic [2:0] m, input logic [1:0] r, input logic [1:0] t,
                       input logic [63:0] exp);
      apply(b, sg, m, r, t, 1'b0);
      chk(req, "result", out_result, exp);
   endtask

   task automatic t_reset();
      chk("R12", "reset valid", {63'b0, out_valid}, 64'd0);
      chk("R12", "reset result", out_result, 64'd0);
      chk("R12", "reset wr_en", {63'b0, out_wr_en}, 64'd0);
   endtask

   task automatic t_latency_R12();
      apply(D_2, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0);
      chk("R12", "valid one cycle later", {63'b0, out_valid}, 64'd1);
      chk("R12", "result one cycle later", out_result, 64'd2);
      @(negedge clk);
      chk("R12", "valid drops", {63'b0, out_valid}, 64'd0);
   endtask

   task automatic t_modes_R1();
      conv("R1", D_QNAN, 1'b0, 3'd1, 2'd0, 2'd0, 64'hFFFF_FFFF_8000_0000);
      conv("R1", D_QNAN, 1'b0, 3'd3, 2'd0, 2'd0, 64'd0);
      conv("R1", D_P32P5, 1'b0, 3'd5, 2'd0, 2'd0, 64'd5);
      for (int m = 6; m < 8; m++) begin
         apply(D_2P5, 1'b0, 3'(m), 2'd0, 2'd2, 1'b0);
         chk("R1", "illegal flag", {63'b0, out_bad_mode}, 64'd1);
         chk("R1", "illegal no write", {63'b0, out_wr_en}, 64'd0);
         chk("R1", "illegal result", out_result, 64'd0);
         chk("R1", "illegal overflow", {63'b0, out_overflow}, 64'd0);
      end
   endtask

   task automatic t_rounding_R2();
      conv("R2", D_2P5, 1'b0, 3'd0, 2'd0, 2'd2, 64'd2);
      conv("R2", D_3P5, 1'b0, 3'd0, 2'd0, 2'd2, 64'd4);
      conv("R2", D_2P5, 1'b0, 3'd0, 2'd2, 2'd2, 64'd3);
      conv("R2", D_N2P5, 1'b0, 3'd0, 2'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFD);
      conv("R2", D_N2P5, 1'b0, 3'd0, 2'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFE);
      conv("R2", D_3P5, 1'b0, 3'd1, 2'd0, 2'd2, 64'd3);
      conv("R2", D_3P5, 1'b0, 3'd3, 2'd2, 2'd2, 64'd3);
      conv("R2", D_NHALF, 1'b0, 3'd0, 2'd2, 2'd2, 64'd0);
      conv("R2", D_NHALF, 1'b0, 3'd0, 2'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_types_R3();
      conv("R3", D_N1, 1'b0, 3'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      conv("R3", D_N31, 1'b0, 3'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_8000_0000);
      conv("R3", D_P31, 1'b0, 3'd0, 2'd0, 2'd1, 64'h0000_0000_8000_0000);
      conv("R3", D_P31, 1'b0, 3'd0, 2'd0, 2'd3, 64'h0000_0000_8000_0000);
   endtask

   task automatic t_clamp_R4();
      apply(D_P31, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R4", "s32 max", out_result, 64'h0000_0000_7FFF_FFFF);
      chk("R4", "s32 max invalid", {63'b0, out_inv_cvt}, 64'd1);
      apply(D_N1, 1'b0, 3'd2, 2'd0, 2'd1, 1'b0);
      chk("R4", "u32 min", out_result, 64'd0);
      chk("R4", "u32 min invalid", {63'b0, out_inv_cvt}, 64'd1);
      conv("R4", D_P64, 1'b0, 3'd0, 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      conv("R4", D_P63, 1'b0, 3'd2, 2'd0, 2'd2, 64'h7FFF_FFFF_FFFF_FFFF);
      apply(D_N63, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0);
      chk("R4", "s64 exact min", out_result, 64'h8000_0000_0000_0000);
      chk("R4", "s64 exact min valid", {63'b0, out_inv_cvt}, 64'd0);
      conv("R4", D_NINF, 1'b0, 3'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_8000_0000);
      conv("R4", D_PINF, 1'b0, 3'd2, 2'd0, 2'd1, 64'h0000_0000_FFFF_FFFF);
   endtask

   task automatic t_nan_R5();
      conv("R5", D_QNAN, 1'b0, 3'd0, 2'd0, 2'd0, 64'hFFFF_FFFF_8000_0000);
      conv("R5", D_QNAN, 1'b0, 3'd2, 2'd0, 2'd0, 64'd0);
      conv("R5", D_QNAN, 1'b0, 3'd0, 2'd0, 2'd3, 64'd0);
      conv("R5", D_QNAN, 1'b0, 3'd0, 2'd0, 2'd2, 64'h8000_0000_0000_0000);
      conv("R5", D_SNAN, 1'b0, 3'd3, 2'd0, 2'd2, 64'd0);
   endtask

   task automatic t_wrap_R6();
      apply(D_P32P5, 1'b0, 3'd4, 2'd0, 2'd0, 1'b0);
      chk("R6", "wrap 2^32+5", out_result, 64'd5);
      chk("R6", "wrap not invalid", {63'b0, out_inv_cvt}, 64'd0);
      conv("R6", D_N1, 1'b0, 3'd4, 2'd0, 2'd1, 64'h0000_0000_FFFF_FFFF);
      conv("R6", D_P31, 1'b0, 3'd4, 2'd0, 2'd0, 64'hFFFF_FFFF_8000_0000);
      conv("R6", D_P64P12, 1'b0, 3'd4, 2'd0, 2'd2, 64'h0000_0000_0000_1000);
      conv("R6", D_P117, 1'b0, 3'd5, 2'd0, 2'd3, 64'd0);
      apply(D_PINF, 1'b0, 3'd4, 2'd0, 2'd2, 1'b0);
      chk("R6", "wrap inf", out_result, 64'd0);
      chk("R8", "wrap inf invalid", {63'b0, out_inv_cvt}, 64'd1);
      conv("R6", D_QNAN, 1'b0, 3'd5, 2'd0, 2'd0, 64'd0);
   endtask

   task automatic t_overflow_R7();
      apply(D_2, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R7", "exact no overflow", {63'b0, out_overflow}, 64'd0);
      apply(D_2P5, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R7", "fraction overflow", {63'b0, out_overflow}, 64'd1);
      apply(D_N31, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R7", "s32 min exact", {63'b0, out_overflow}, 64'd0);
      apply(D_P32P5, 1'b0, 3'd4, 2'd0, 2'd0, 1'b0);
      chk("R7", "wrapped overflow", {63'b0, out_overflow}, 64'd1);
      apply(D_QNAN, 1'b0, 3'd2, 2'd0, 2'd0, 1'b0);
      chk("R7", "nan overflow", {63'b0, out_overflow}, 64'd1);
      apply(D_NZERO, 1'b0, 3'd0, 2'd0, 2'd1, 1'b0);
      chk("R7", "neg zero result", out_result, 64'd0);
      chk("R7", "neg zero exact", {63'b0, out_overflow}, 64'd0);
   endtask

   task automatic t_invalid_R8();
      apply(D_SNAN, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R8", "snan flag", {63'b0, out_inv_snan}, 64'd1);
      chk("R8", "snan invalid", {63'b0, out_inv_cvt}, 64'd1);
      apply(D_QNAN, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R8", "qnan no snan", {63'b0, out_inv_snan}, 64'd0);
      chk("R8", "qnan invalid", {63'b0, out_inv_cvt}, 64'd1);
      apply(D_2P5, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R8", "in range valid", {63'b0, out_inv_cvt}, 64'd0);
   endtask

   task automatic t_flags_R9();
      apply(D_2P5, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0);
      chk("R9", "tie even inexact", {63'b0, out_inexact}, 64'd1);
      chk("R9", "tie even not up", {63'b0, out_rounded_up}, 64'd0);
      apply(D_1P5, 1'b0, 3'd0, 2'd0, 2'd1, 1'b0);
      chk("R9", "1.5 result", out_result, 64'd2);
      chk("R9", "1.5 rounded up", {63'b0, out_rounded_up}, 64'd1);
      apply(D_2, 1'b0, 3'd0, 2'd0, 2'd2, 1'b0);
      chk("R9", "exact not inexact", {63'b0, out_inexact}, 64'd0);
      apply(64'h41E0_0000_0010_0000, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R9", "invalid not inexact", {63'b0, out_inexact}, 64'd0);
      chk("R9", "invalid not up", {63'b0, out_rounded_up}, 64'd0);
   endtask

   task automatic t_gate_R10();
      apply(D_QNAN, 1'b0, 3'd0, 2'd0, 2'd0, 1'b1);
      chk("R10", "enabled invalid no write", {63'b0, out_wr_en}, 64'd0);
      chk("R10", "enabled invalid result", out_result, 64'd0);
      chk("R10", "enabled invalid flag", {63'b0, out_inv_cvt}, 64'd1);
      apply(D_2P5, 1'b0, 3'd0, 2'd0, 2'd2, 1'b1);
      chk("R10", "enabled valid write", {63'b0, out_wr_en}, 64'd1);
      chk("R10", "enabled valid result", out_result, 64'd2);
      chk("R10", "enabled valid inexact", {63'b0, out_inexact}, 64'd1);
      apply(D_QNAN, 1'b0, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R10", "disabled invalid write", {63'b0, out_wr_en}, 64'd1);
   endtask

   task automatic t_single_R11();
      conv("R11", {32'hDEAD_BEEF, 32'h3FC0_0000}, 1'b1, 3'd0, 2'd0, 2'd0, 64'd2);
      conv("R11", {32'h0123_4567, 32'hC020_0000}, 1'b1, 3'd0, 2'd3, 2'd0,
           64'hFFFF_FFFF_FFFF_FFFD);
      conv("R11", {32'hFFFF_FFFF, 32'h4F00_0000}, 1'b1, 3'd0, 2'd0, 2'd0,
           64'h0000_0000_7FFF_FFFF);
      apply({32'h0, 32'h7F80_0001}, 1'b1, 3'd0, 2'd0, 2'd0, 1'b0);
      chk("R11", "single snan", {63'b0, out_inv_snan}, 64'd1);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_latency_R12();
      t_modes_R1();
      t_rounding_R2();
      t_types_R3();
      t_clamp_R4();
      t_nan_R5();
      t_wrap_R6();
      t_overflow_R7();
      t_invalid_R8();
      t_flags_R9();
      t_gate_R10();
      t_single_R11();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule